// File: doc/BRIEF.md
# Block-Read DMA Disk Controller

This controller moves one run of consecutive 16-bit words from a sector-organised storage stream into system memory without processor help. Software programs four registers through a small word-indexed host register port: a negative word count, a starting memory byte address and a starting sector number. It then writes the read command with the start bit set. From then on the block alternates between two phases. It asks the storage side for the next word of the current sector. It then writes that word to memory as bus master. This continues until the count reaches zero.

Completion appears as bit 7 of the control/status register. A driver can therefore wait with a signed test of the register's low byte. While the transfer runs, the count, address and sector registers move with it, so reading them afterwards shows where the transfer stopped. The storage side is addressed by a sector number and a word offset within that sector. After the last word of a sector the sector number steps by one, so multi-sector runs come out in order.

Top module: `blkrd_dma`

## Requirements
- R1: After reset the control/status register reads 0x0080 (ready set, function 0). The count, memory address, sector and data registers read 0, and neither `sto_req` nor `mem_wr` is asserted.
- R2: `reg_addr` selects a register by word index: 0 control/status, 1 word count, 2 memory address, 3 sector, 4 data buffer (byte offsets 0, 2, 4, 6 and 10 octal). While ready, registers 1 to 3 read back the value last written, and indexes 5 to 7 read 0.
- R3: A write to control/status while ready stores bits 3:1 as the function field, which reads back in bits 3:1. The write starts a transfer and clears ready only when bit 0 (go) is 1 and the function is 2 (read), as with the value 5. A go with any other function leaves ready set and starts nothing.
- R4: The word count holds the two's complement of the number of words. Exactly that many words are written to memory, the count rises by 1 per word, and it reads 0 at the end. For example, 0xFF08 (177410 octal) moves 248 (370 octal) words.
- R5: Each word is written to memory at the current memory address register value, and that register then rises by 2.
- R6: The storage side is asked for words at `sto_sector` equal to the sector register, starting at word offset 0. The offset rises by 1 per word. After word offset SECTOR_WORDS-1 the sector register rises by 1 and the offset returns to 0.
- R7: Ready (control/status bit 7) is set in the cycle after the last word's memory acknowledge, so the low byte then reads as a negative byte.
- R8: The data buffer register reads the most recently transferred word.
- R9: While a transfer runs, host writes to any register are ignored, including a second go. A write that falls in the cycle of the final memory acknowledge is also ignored.
- R10: `mem_wr` holds its address and data stable until `mem_ack`, and `sto_req` and `mem_wr` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register word index |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for `reg_addr` |
| sto_req | output | 1 | Request for the next storage word |
| sto_sector | output | 16 | Sector number of the requested word |
| sto_word | output | SWB | Word offset within the sector |
| sto_valid | input | 1 | Storage word present; accepted while `sto_req` is high |
| sto_data | input | 16 | Storage word |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory write accepted |

## Verification
Two functions can meet in a single cycle: a host register write and the memory acknowledge of the final word, which is the moment completion sets ready. The bench provokes this by issuing a host write on every cycle of a transfer, cycling through a second go and new count, address and sector values, so one write is sure to land on the completing cycle. The outcome is judged at the ports. The count, address and sector must show exactly the values the original transfer produces, the number of memory writes must equal the programmed count, and ready must be set.

// File: rtl/blkrd_dma.sv
module blkrd_dma #(
  parameter int SECTOR_WORDS = 256,
  parameter int SWB = $clog2(SECTOR_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [2:0]     reg_addr,
  input  logic [15:0]    reg_wdata,
  output logic [15:0]    reg_rdata,
  output logic           sto_req,
  output logic [15:0]    sto_sector,
  output logic [SWB-1:0] sto_word,
  input  logic           sto_valid,
  input  logic [15:0]    sto_data,
  output logic           mem_wr,
  output logic [15:0]    mem_addr,
  output logic [15:0]    mem_wdata,
  input  logic           mem_ack
);
  localparam logic [2:0]     FN_READ  = 3'd2;
  localparam logic [SWB-1:0] LAST_OFS = SWB'(SECTOR_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WRITE} state_t;
  state_t state_q;

  logic [2:0]     fn_q;
  logic [15:0]    wc_q, ba_q, da_q, db_q, hold_q;
  logic [SWB-1:0] ofs_q;

  wire ready_w  = (state_q == S_IDLE);
  wire host_ok  = reg_wr && ready_w;
  wire go_w     = host_ok && reg_addr == 3'd0 && reg_wdata[0] && reg_wdata[3:1] == FN_READ;
  wire take_w   = (state_q == S_FETCH) && sto_valid;
  wire put_w    = (state_q == S_WRITE) && mem_ack;
  wire [15:0] wc_nx = wc_q + 16'd1;

  assign sto_req    = (state_q == S_FETCH);
  assign sto_sector = da_q;
  assign sto_word   = ofs_q;
  assign mem_wr     = (state_q == S_WRITE);
  assign mem_addr   = ba_q;
  assign mem_wdata  = hold_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {8'h00, ready_w, 3'b000, fn_q, 1'b0};
      3'd1:    reg_rdata = wc_q;
      3'd2:    reg_rdata = ba_q;
      3'd3:    reg_rdata = da_q;
      3'd4:    reg_rdata = db_q;
      default: reg_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      fn_q    <= 3'd0;
      wc_q    <= 16'h0000;
      ba_q    <= 16'h0000;
      da_q    <= 16'h0000;
      db_q    <= 16'h0000;
      hold_q  <= 16'h0000;
      ofs_q   <= '0;
    end else begin
      if (host_ok) begin
        case (reg_addr)
          3'd0: fn_q <= reg_wdata[3:1];
          3'd1: wc_q <= reg_wdata;
          3'd2: ba_q <= reg_wdata;
          3'd3: da_q <= reg_wdata;
          default: ;
        endcase
      end
      if (go_w) begin
        state_q <= S_FETCH;
        ofs_q   <= '0;
      end
      if (take_w) begin
        hold_q  <= sto_data;
        state_q <= S_WRITE;
      end
      if (put_w) begin
        db_q <= hold_q;
        ba_q <= ba_q + 16'd2;
        wc_q <= wc_nx;
        if (ofs_q == LAST_OFS) begin
          ofs_q <= '0;
          da_q  <= da_q + 16'd1;
        end else begin
          ofs_q <= ofs_q + 1'b1;
        end
        state_q <= (wc_nx == 16'h0000) ? S_IDLE : S_FETCH;
      end
    end
  end
endmodule

// File: rtl/blkrd_dma_chk.sv
module blkrd_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        ready,
  input logic        sto_req,
  input logic        mem_wr,
  input logic        mem_ack,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic [15:0] wc,
  input logic [15:0] ba
);
  a_r3_go_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && reg_wr && reg_addr == 3'd0 && reg_wdata[3:0] == 4'h5) |=> !ready);

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ack) |=> (ba == $past(ba) + 16'd2));

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ack) |=> (wc == $past(wc) + 16'd1));

  a_r7_ready_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (wc == 16'h0000));

  a_r9_busy_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && reg_wr && reg_addr == 3'd2) |=>
      (ba == $past(ba) || ba == $past(ba) + 16'd2));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sto_req && mem_wr));
endmodule

bind blkrd_dma blkrd_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .ready(ready_w), .sto_req(sto_req), .mem_wr(mem_wr),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .wc(wc_q), .ba(ba_q)
);

// File: tb/blkrd_dma_test.sv
module blkrd_dma_test;
  localparam int CLK_PERIOD = 10;
  localparam int SECTOR_WORDS = 256;
  localparam int SWB = 8;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic sto_req, sto_valid, mem_wr, mem_ack;
  logic [15:0] sto_sector, sto_data, mem_addr, mem_wdata;
  logic [SWB-1:0] sto_word;

  int errors = 0, checks = 0, nwr = 0, overlap = 0;
  logic [15:0] mem [0:1023];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkrd_dma #(.SECTOR_WORDS(SECTOR_WORDS)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sto_req(sto_req),
    .sto_sector(sto_sector), .sto_word(sto_word), .sto_valid(sto_valid),
    .sto_data(sto_data), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack)
  );

  function automatic logic [15:0] pat(input logic [15:0] s, input int w);
    return {s[7:0], 8'(w)} ^ 16'hA5C3;
  endfunction

  assign sto_data  = pat(sto_sector, int'(sto_word));
  assign sto_valid = lfsr[0] | lfsr[3];
  assign mem_ack   = lfsr[5] | lfsr[9];

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always @(posedge clk) begin
    if (mem_wr && mem_ack) begin
      mem[mem_addr[10:1]] <= mem_wdata;
      nwr <= nwr + 1;
    end
    if (sto_req && mem_wr) overlap <= overlap + 1;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [15:0] v);
    @(negedge clk); reg_wr = 1; reg_addr = idx; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [15:0] v);
    @(negedge clk); reg_addr = idx; #1 v = reg_rdata;
  endtask

  task automatic wait_ready();
    logic [15:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd0, v);
      if (v[7]) return;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, v); chk("R1 csr", v, 16'h0080);
    rd(3'd1, v); chk("R1 wc", v, 0);
    rd(3'd2, v); chk("R1 ba", v, 0);
    rd(3'd3, v); chk("R1 da", v, 0);
    rd(3'd4, v); chk("R1 db", v, 0);
    chk("R1 idle outputs", {15'd0, sto_req | mem_wr}, 0);
  endtask

  task automatic t_regmap();
    logic [15:0] v;
    wr(3'd1, 16'h1234); wr(3'd2, 16'hBEEE); wr(3'd3, 16'h0042);
    rd(3'd1, v); chk("R2 wc", v, 16'h1234);
    rd(3'd2, v); chk("R2 ba", v, 16'hBEEE);
    rd(3'd3, v); chk("R2 da", v, 16'h0042);
    rd(3'd5, v); chk("R2 unused", v, 0);
    rd(3'd7, v); chk("R2 unused7", v, 0);
  endtask

  task automatic t_badfunc();
    logic [15:0] v;
    int n0 = nwr;
    wr(3'd0, 16'h0003);
    repeat (20) @(negedge clk);
    rd(3'd0, v); chk("R3 bad function ignored", v, 16'h0082);
    chk("R3 no words", 16'(nwr - n0), 0);
  endtask

  task automatic t_short();
    logic [15:0] v;
    int n0;
    wr(3'd1, 16'hFFFB); wr(3'd2, 16'h0100); wr(3'd3, 16'h0003);
    n0 = nwr;
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 16'h0005;
    @(negedge clk); reg_wr = 0;
    chk("R6 sector", sto_sector, 16'h0003);
    chk("R6 first offset", {8'h00, sto_word}, 0);
    chk("R3 go clears ready", {15'd0, reg_rdata[7]}, 0);
    wait_ready();
    chk("R4 five words", 16'(nwr - n0), 5);
    for (int i = 0; i < 5; i++) chk("R5 memory word", mem[128 + i], pat(16'h3, i));
    rd(3'd1, v); chk("R4 count zero", v, 0);
    rd(3'd2, v); chk("R5 address end", v, 16'h010A);
    rd(3'd3, v); chk("R6 sector kept", v, 16'h0003);
    rd(3'd4, v); chk("R8 last word", v, pat(16'h3, 4));
    rd(3'd0, v); chk("R7 csr ready", v, 16'h0084);
    chk("R7 low byte negative", {15'd0, v[7]}, 1);
  endtask

  task automatic t_len370();
    logic [15:0] v;
    int n0;
    wr(3'd1, 16'hFF08); wr(3'd2, 16'h0000); wr(3'd3, 16'h0000);
    n0 = nwr;
    wr(3'd0, 16'h0005);
    wait_ready();
    chk("R4 370 octal words", 16'(nwr - n0), 16'd248);
    chk("R5 first word at 0", mem[0], pat(16'h0, 0));
    chk("R5 last word", mem[247], pat(16'h0, 247));
    rd(3'd2, v); chk("R5 address end", v, 16'd496);
    rd(3'd3, v); chk("R6 no sector step", v, 0);
  endtask

  task automatic t_sector();
    logic [15:0] v;
    int n0;
    wr(3'd1, -16'sd300); wr(3'd2, 16'h0200); wr(3'd3, 16'h0007);
    n0 = nwr;
    wr(3'd0, 16'h0005);
    wait_ready();
    chk("R4 300 words", 16'(nwr - n0), 16'd300);
    chk("R6 end of sector", mem[256 + 255], pat(16'h7, 255));
    chk("R6 next sector start", mem[256 + 256], pat(16'h8, 0));
    rd(3'd3, v); chk("R6 sector stepped", v, 16'h0008);
    rd(3'd2, v); chk("R5 address end", v, 16'h0200 + 16'd600);
    rd(3'd4, v); chk("R8 last word", v, pat(16'h8, 43));
  endtask

  task automatic t_busy();
    logic [15:0] v;
    int n0, k;
    wr(3'd1, 16'hFFFC); wr(3'd2, 16'h0040); wr(3'd3, 16'h0001);
    n0 = nwr;
    wr(3'd0, 16'h0005);
    k = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!(sto_req || mem_wr)) break;
      reg_wr = 1; reg_addr = 3'(k % 4);
      case (k % 4)
        0: reg_wdata = 16'h0005;
        1: reg_wdata = 16'h0000;
        2: reg_wdata = 16'h0777;
        default: reg_wdata = 16'h0055;
      endcase
      k++;
    end
    reg_wr = 0;
    chk("R9 word count unchanged by writes", 16'(nwr - n0), 4);
    rd(3'd1, v); chk("R9 count", v, 0);
    rd(3'd2, v); chk("R9 address", v, 16'h0048);
    rd(3'd3, v); chk("R9 sector", v, 16'h0001);
    rd(3'd4, v); chk("R8 last word", v, pat(16'h1, 3));
    rd(3'd0, v); chk("R9 csr ready", v, 16'h0084);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regmap();
    t_badfunc();
    t_short();
    t_len370();
    t_sector();
    t_busy();
    chk("R10 no overlap", 16'(overlap), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule